// File: doc/BRIEF.md
# Serial Trigger Line Decoder

The block turns one synchronous, idle-low trigger wire into eight separate one-cycle trigger strobes. A symbol opens with a single high start bit, after which three bits name the strobe to fire. When enabled, a 32-bit spill/trigger number follows the three vector bits and is presented with a one-cycle valid flag. No board address is carried, so every receiver on the wire acts on every symbol.

A run-time delay of 0 to 6 clocks is applied to the line before decoding, so that boards on cables of different lengths can be trimmed to respond in the same cycle. A line held high for more than fifty consecutive samples is treated as a board reset rather than as a trigger stream. After that reset, decoding stays suspended until the line is seen low again.

Top module: `trig_line_decoder`

## Requirements
- R1: While and right after rst_ni is low, trig_o, num_o, num_valid_o and board_rst_o are all zero.
- R2: A symbol is a 1 on the idle-low delayed line (start bit) followed by three vector bits, MSB first. Vector value v drives trig_o[v] high for exactly one cycle, and the other seven bits stay low.
- R3: If the start bit is sampled at clock edge t, trig_o is high from edge t+3 until edge t+4. With delay 0, a start bit driven before edge t is sampled at edge t.
- R4: With num_en_i high, the 32 bits after the vector (sampled at edges t+4 to t+35) are taken MSB first. At edge t+35 they are loaded into num_o and num_valid_o goes high for one cycle.
- R5: While the 32 number bits are being received, high bits are not treated as start bits and raise no trigger.
- R6: With num_en_i low, num_valid_o stays low and num_o keeps its last value. The start-bit search resumes with the bit right after the third vector bit.
- R7: delay_i = d with d from 0 to 6 delays every decoded event by d clocks. Any value above 6 acts as 6.
- R8: When the delayed line is high on 51 consecutive samples, board_rst_o pulses for one cycle after the 51st sample edge, once per high period. Exactly 50 high samples raise no reset.
- R9: From the edge after a board reset fires until the line is sampled low, no trigger or number is produced, and a symbol that was partly received is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial trigger line, idle low |
| delay_i | input | 3 | Cable equalisation delay in clocks (0..6, larger clamps to 6) |
| num_en_i | input | 1 | Receive the 32-bit number after each vector |
| trig_o | output | 8 | One-cycle trigger strobes, one per vector value |
| num_o | output | 32 | Last received spill/trigger number |
| num_valid_o | output | 1 | One-cycle flag when num_o has been updated |
| board_rst_o | output | 1 | One-cycle board reset pulse |

## Verification
A wrong decoder state or bit counter shows up as a strobe on the wrong line, a strobe off by a cycle, or an unexpected extra strobe. The scoreboard catches each of these at the first event that follows, because it checks the expected cycle as well as the value. A number that is misaligned, or a lost suspension of the start-bit search, shows up within 36 clocks as a wrong num_o value or as spurious triggers during the number. A fault in the high-run counter or the block flag shows up at the 51st high sample as a missing or early reset, or as trigger strobes continuing during the long high.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned VEC_W   = 3;
  localparam int unsigned N_TRIG  = 1 << VEC_W;
  localparam int unsigned NUM_W   = 32;
  localparam int unsigned MAX_DLY = 6;
  localparam int unsigned DLY_W   = 3;
  localparam int unsigned RST_LEN = 50;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_VEC,
    ST_NUM
  } dec_state_e;
endpackage

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int unsigned MAX_DLY = trig_pkg::MAX_DLY,
  parameter int unsigned DLY_W   = trig_pkg::DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             line_o
);
  logic [MAX_DLY-1:0] tap_q;
  logic [DLY_W-1:0]   sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q[0] <= 1'b0;
    else         tap_q[0] <= line_i;
  end

  for (genvar g = 1; g < MAX_DLY; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[g] <= 1'b0;
      else         tap_q[g] <= tap_q[g-1];
    end
  end

  assign sel    = (delay_i > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : delay_i;
  assign line_o = (sel == '0) ? line_i : tap_q[sel - 1'b1];
endmodule

// File: rtl/trig_reset_detect.sv
module trig_reset_detect #(
  parameter int unsigned RST_LEN = trig_pkg::RST_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic board_rst_o,
  output logic blk_o
);
  localparam int unsigned CNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] hi_cnt_q;
  logic             fire;

  // hi_cnt_q = consecutive high samples before this one, saturating
  assign fire = line_i && (hi_cnt_q == CNT_W'(RST_LEN)) && !blk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q    <= '0;
      blk_o       <= 1'b0;
      board_rst_o <= 1'b0;
    end else begin
      board_rst_o <= fire;
      if (!line_i) begin
        hi_cnt_q <= '0;
        blk_o    <= 1'b0;
      end else begin
        if (hi_cnt_q != CNT_W'(RST_LEN)) hi_cnt_q <= hi_cnt_q + 1'b1;
        if (fire) blk_o <= 1'b1;
      end
    end
  end

  // R8
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rst_o |=> !board_rst_o);
  // R8
  rst_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rst_o |-> blk_o);
  // R9
  low_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> !blk_o);
endmodule

// File: rtl/trig_symbol_fsm.sv
module trig_symbol_fsm
  import trig_pkg::*;
#(
  parameter int unsigned VEC_W  = trig_pkg::VEC_W,
  parameter int unsigned N_TRIG = 1 << VEC_W,
  parameter int unsigned NUM_W  = trig_pkg::NUM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              blk_i,
  input  logic              num_en_i,
  output logic [N_TRIG-1:0] trig_o,
  output logic [NUM_W-1:0]  num_o,
  output logic              num_valid_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W);

  dec_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [VEC_W-1:0] vec_q;
  logic [NUM_W-1:0] num_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      vec_q       <= '0;
      num_sh_q    <= '0;
      trig_o      <= '0;
      num_o       <= '0;
      num_valid_o <= 1'b0;
    end else begin
      trig_o      <= '0;
      num_valid_o <= 1'b0;
      if (blk_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (line_i) state_q <= ST_VEC;
          end
          ST_VEC: begin
            vec_q <= {vec_q[VEC_W-2:0], line_i};
            if (cnt_q == CNT_W'(VEC_W - 1)) begin
              trig_o  <= N_TRIG'(1) << {vec_q[VEC_W-2:0], line_i};
              cnt_q   <= '0;
              state_q <= num_en_i ? ST_NUM : ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_NUM: begin
            num_sh_q <= {num_sh_q[NUM_W-2:0], line_i};
            if (cnt_q == CNT_W'(NUM_W - 1)) begin
              num_o       <= {num_sh_q[NUM_W-2:0], line_i};
              num_valid_o <= 1'b1;
              cnt_q       <= '0;
              state_q     <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  trig_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trig_o));
  // R2
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o != '0) |=> (trig_o == '0));
  // R4
  num_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    num_valid_o |=> !num_valid_o);
  // R9
  blk_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i |=> (trig_o == '0) && !num_valid_o);
  // R5
  num_no_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NUM) |=> (trig_o == '0));
endmodule

// File: rtl/trig_line_decoder.sv
module trig_line_decoder
  import trig_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic [DLY_W-1:0]     delay_i,
  input  logic                 num_en_i,
  output logic [N_TRIG-1:0]    trig_o,
  output logic [NUM_W-1:0]     num_o,
  output logic                 num_valid_o,
  output logic                 board_rst_o
);
  logic line_d;
  logic blk;

  trig_delay_line #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .delay_i(delay_i),
    .line_o (line_d)
  );

  trig_reset_detect #(.RST_LEN(RST_LEN)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_d),
    .board_rst_o(board_rst_o),
    .blk_o      (blk)
  );

  trig_symbol_fsm #(.VEC_W(VEC_W), .N_TRIG(N_TRIG), .NUM_W(NUM_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_d),
    .blk_i      (blk),
    .num_en_i   (num_en_i),
    .trig_o     (trig_o),
    .num_o      (num_o),
    .num_valid_o(num_valid_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (trig_o == '0) && !num_valid_o && !board_rst_o);
endmodule

// File: tb/trig_line_decoder_tb.sv
module trig_line_decoder_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;   // 0 trigger, 1 number, 2 reset
    logic [31:0] val;
    int          cyc;
    string       req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_i = 1'b0;
  logic [2:0]  delay_i = '0;
  logic        num_en_i = 1'b0;
  logic [7:0]  trig_o;
  logic [31:0] num_o;
  logic        num_valid_o;
  logic        board_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  exp_t q[$];

  trig_line_decoder u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .delay_i    (delay_i),
    .num_en_i   (num_en_i),
    .trig_o     (trig_o),
    .num_o      (num_o),
    .num_valid_o(num_valid_o),
    .board_rst_o(board_rst_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int eff_d();
    return (delay_i > 3'd6) ? 6 : int'(delay_i);
  endfunction

  function automatic void push(int kind, logic [31:0] val, int at, string req);
    exp_t e;
    e.kind = kind; e.val = val; e.cyc = at; e.req = req;
    q.push_back(e);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bit_tx(logic b);
    line_i = b;
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) bit_tx(1'b0);
  endtask

  // start bit sampled at s = cyc+1+d; trigger seen at s+3, number at s+35
  task automatic symbol(logic [2:0] v, logic [31:0] num, string req);
    int s;
    s = cyc + 1 + eff_d();
    push(0, 32'(8'(1) << v), s + 3, req);
    if (num_en_i) push(1, num, s + 35, "R4");
    bit_tx(1'b1);
    for (int i = 2; i >= 0; i--) bit_tx(v[i]);
    if (num_en_i) for (int i = 31; i >= 0; i--) bit_tx(num[i]);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (trig_o != '0)  match(0, 32'(trig_o));
      if (num_valid_o)   match(1, num_o);
      if (board_rst_o)   match(2, 32'd1);
    end
  end

  task automatic match(int kind, logic [31:0] val);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, (kind == 2) ? "R8" : "R5", $sformatf("unexpected kind %0d", kind), val, 0);
      return;
    end
    e = q.pop_front();
    chk(e.kind == kind, e.req, "event kind", 32'(kind), 32'(e.kind));
    chk(e.val == val, e.req, "event value", val, e.val);
    chk(e.cyc == cyc, (e.kind == 0) ? "R3" : e.req, "event cycle", 32'(cyc), 32'(e.cyc));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk_i);
    // R1
    chk(trig_o == '0 && num_o == '0 && !num_valid_o && !board_rst_o, "R1",
        "outputs in reset", {trig_o, 24'(num_valid_o)}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(trig_o == '0 && num_o == '0 && !num_valid_o && !board_rst_o, "R1",
        "outputs after reset", 32'(trig_o), 0);

    // R2 R3: every vector, delay 0, no number
    for (int v = 0; v < 8; v++) begin
      symbol(3'(v), 0, "R2");
      idle(2);
    end

    // R6: back-to-back symbols, bit after vector is searched for start
    symbol(3'd5, 0, "R6");
    symbol(3'd2, 0, "R6");
    idle(4);

    // R4 R5: numbers with many ones must not raise triggers
    num_en_i = 1'b1;
    symbol(3'd3, 32'hA5F0_1E69, "R4");
    idle(2);
    symbol(3'd6, 32'hFFFF_FFFF, "R5");
    symbol(3'd0, 32'h8000_0001, "R4");
    idle(4);
    num_en_i = 1'b0;
    idle(2);

    // R6: number disabled, num_o retained, no valid
    symbol(3'd1, 0, "R6");
    symbol(3'd7, 0, "R6");
    idle(6);
    chk(num_o == 32'h8000_0001, "R6", "num_o retained", num_o, 32'h8000_0001);

    // R7: delays 3, 6 and 7 (clamped)
    delay_i = 3'd3; idle(10);
    symbol(3'd2, 0, "R7"); idle(12);
    delay_i = 3'd6; idle(10);
    symbol(3'd4, 0, "R7"); idle(12);
    delay_i = 3'd7; idle(10);
    symbol(3'd6, 0, "R7"); idle(12);
    delay_i = 3'd0; idle(10);

    // R8: exactly 50 high samples -> twelve vector-7 triggers, trailing 1,0,0 -> vector 4
    s = cyc + 1;
    for (int k = 0; k < 12; k++) push(0, 32'h80, s + 3 + 4*k, "R8");
    push(0, 32'h10, s + 51, "R8");
    for (int i = 0; i < 50; i++) bit_tx(1'b1);
    idle(12);

    // R8 R9: 60 high samples -> twelve triggers, one reset, then silence
    s = cyc + 1;
    for (int k = 0; k < 12; k++) push(0, 32'h80, s + 3 + 4*k, "R9");
    push(2, 32'd1, s + 50, "R8");
    for (int i = 0; i < 60; i++) bit_tx(1'b1);
    idle(10);

    // R9: decoding resumes once the line was low
    symbol(3'd5, 0, "R9");
    idle(10);

    chk(q.size() == 0, "R3", "missing events", 32'(q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule